// File: doc/BRIEF.md
# Guarded Clock Divider Setting Register

This block holds the setting of one clock divider whose parent clock can run at more than one rate. Software writes a new divider code through a 32-bit write port; the write only takes effect when the field's write-enable bit is set in the same word. An accepted code is handed to the divider with a one-cycle load strobe, and a busy bit stays set until the divider answers with a done pulse. A write that arrives while the field is busy waits in a one-entry holding slot. A further write while that slot is full is dropped and raises a sticky overflow flag.

The block also protects the divider from an illegal ratio. Code 0 means divide-by-1, and divide-by-1 is not allowed when the parent runs at its restricted rate. Before the parent moves, the rate-change logic raises a request with a flag that says whether the new rate is the restricted one. If it is, and the field holds code 0, the block first rewrites the field to code 1 (divide-by-2), waits for the divider's done pulse, and only then acknowledges. In every other case it acknowledges at once and leaves the field alone. While the parent is restricted, or while a request to move there is pending, a software write of code 0 is refused and sets a sticky error flag.

Read word layout: bits [DIV_W-1:0] hold the current code. Bit 8 is busy, bit 9 is the reject error, bit 10 is overflow, and bit 11 shows that the parent is at the restricted rate.

Top module: `guarded_div_ctrl`

## Requirements
- R1: A write changes the code only if write-enable bit 16 is set in the same word; the new code is taken from bits [DIV_W-1:0]. A write without bit 16 has no effect on any state.
- R2: After reset the code equals RST_CODE (default 0), and busy, error, overflow and restricted (read bits 8 to 11) are all 0.
- R3: An accepted write, when the field is idle with no held write, updates the code, sets busy and pulses div_load on the next clock edge. Busy clears on the edge that samples div_done.
- R4: A write accepted while busy, or while a write is held, goes into the one-entry slot. The slot is applied (code updated, div_load pulsed) on the first edge at which busy is clear.
- R5: A write accepted while the slot is full and not draining in that cycle is dropped and sets sticky overflow (read bit 10).
- R6: A rate request toward the restricted rate, served while the code is 0, rewrites the code to 1 with a div_load pulse. rate_ack pulses on the edge after div_done, and the restricted bit (read bit 11) is set on that edge.
- R7: A rate request is served when the field is idle with no held write and no write is accepted in that cycle. If no rewrite is needed it is acknowledged on the next edge, the code is unchanged, and the restricted bit takes the request's flag.
- R8: A write of code 0 is refused, and sets sticky error (read bit 9), when the restricted bit is set or a request toward the restricted rate is pending. The code and the slot are unchanged by such a write.
- R9: A rate request that arrives while busy, or while a write is held, is not served until those updates complete, so a held code-0 write is fixed by the forced rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word: code in [DIV_W-1:0], write-enable at bit 16 |
| rd_data | output | 32 | Read word: code, busy (8), error (9), overflow (10), restricted (11) |
| rate_req | input | 1 | Parent rate-change request, held until rate_ack |
| rate_to_restricted | input | 1 | The requested parent rate forbids divide-by-1 |
| rate_ack | output | 1 | One-cycle acknowledge of the rate request |
| div_code | output | DIV_W | Code presented to the divider |
| div_load | output | 1 | One-cycle strobe: divider should take div_code |
| div_done | input | 1 | Divider reports the new code is active |

## Verification
All outputs are registered, so each response appears on the first clock edge after the cycle that causes it. A direct write shows its code and load strobe one edge after the write. Busy drops one edge after done. A held write loads one edge after busy drops. The acknowledge follows the served request or the done pulse by one edge. The bench drives inputs and compares the design against its own cycle model on falling edges, so each result is sampled half a cycle after the edge that makes it. Directed checks also confirm the forced rewrite, the refusals and the overflow at the settled points of each scenario.

// File: rtl/guarded_div_ctrl.sv
module guarded_div_ctrl #(
  parameter int DIV_W    = 2,
  parameter int RST_CODE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             rate_req,
  input  logic             rate_to_restricted,
  output logic             rate_ack,
  output logic [DIV_W-1:0] div_code,
  output logic             div_load,
  input  logic             div_done
);
  localparam int WEN_BIT = 16;
  localparam logic [DIV_W-1:0] RST_V = DIV_W'(RST_CODE);
  localparam logic [DIV_W-1:0] SAFE_V = DIV_W'(1);

  logic [DIV_W-1:0] code_r, hold_r;
  logic busy_r, hold_v, err_r, ovf_r, restr_r, forcing_r;

  logic [DIV_W-1:0] wval;
  logic wr_sel, restr_eff, reject, wr_ok;
  logic drain, direct, serve, force_wr;

  assign wval      = wr_data[DIV_W-1:0];
  assign wr_sel    = wr_en & wr_data[WEN_BIT];
  assign restr_eff = restr_r | (rate_req & rate_to_restricted);
  assign reject    = wr_sel & (wval == '0) & restr_eff;
  assign wr_ok     = wr_sel & ~reject;

  assign drain    = ~busy_r & hold_v;
  assign direct   = ~busy_r & ~hold_v & wr_ok;
  assign serve    = ~busy_r & ~hold_v & ~wr_ok & rate_req & ~forcing_r & ~rate_ack;
  assign force_wr = serve & rate_to_restricted & (code_r == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_r    <= RST_V;
      hold_r    <= '0;
      hold_v    <= 1'b0;
      busy_r    <= 1'b0;
      err_r     <= 1'b0;
      ovf_r     <= 1'b0;
      restr_r   <= 1'b0;
      forcing_r <= 1'b0;
      rate_ack  <= 1'b0;
      div_load  <= 1'b0;
    end else begin
      div_load <= drain | direct | force_wr;
      rate_ack <= 1'b0;
      if (reject) err_r <= 1'b1;

      if (busy_r && div_done) begin
        busy_r <= 1'b0;
        if (forcing_r) begin
          forcing_r <= 1'b0;
          rate_ack  <= 1'b1;
          restr_r   <= rate_to_restricted;
        end
      end

      if (drain) begin
        code_r <= hold_r;
        busy_r <= 1'b1;
      end else if (direct) begin
        code_r <= wval;
        busy_r <= 1'b1;
      end else if (force_wr) begin
        code_r    <= SAFE_V;
        busy_r    <= 1'b1;
        forcing_r <= 1'b1;
      end else if (serve) begin
        rate_ack <= 1'b1;
        restr_r  <= rate_to_restricted;
      end

      if (wr_ok && (busy_r || hold_v)) begin
        if (hold_v && !drain) begin
          ovf_r <= 1'b1;
        end else begin
          hold_r <= wval;
          hold_v <= 1'b1;
        end
      end else if (drain) begin
        hold_v <= 1'b0;
      end
    end
  end

  assign div_code = code_r;
  always_comb begin
    rd_data = '0;
    rd_data[DIV_W-1:0] = code_r;
    rd_data[8]  = busy_r;
    rd_data[9]  = err_r;
    rd_data[10] = ovf_r;
    rd_data[11] = restr_r;
  end

  // R6
  restricted_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restr_r |-> (code_r != '0));
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && !div_done) |=> busy_r);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_r |=> ovf_r);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_r |=> err_r);
  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ack |=> !rate_ack);
  // R4
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> !div_load);
endmodule

// File: tb/guarded_div_ctrl_bench.sv
module guarded_div_ctrl_bench;
  localparam int LAT = 6;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rate_req = 0, rate_to_restricted = 0, div_done = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic rate_ack, div_load;
  logic [1:0] div_code;
  int checks = 0, failures = 0, cyc = 0, dcnt = 0;

  guarded_div_ctrl u_guarded_div_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rate_req(rate_req), .rate_to_restricted(rate_to_restricted), .rate_ack(rate_ack),
    .div_code(div_code), .div_load(div_load), .div_done(div_done));

  always #5 clk = ~clk;

  // behavioural reference model
  int m_code, m_busy, m_err, m_ovf, m_restr, m_forcing, m_ack, m_load;
  int q[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 0; m_busy = 0; m_err = 0; m_ovf = 0; m_restr = 0;
      m_forcing = 0; m_ack = 0; m_load = 0; q.delete();
    end else begin
      int v, prev_ack, sel, ok, pend_r;
      v = int'(wr_data[1:0]);
      sel = (wr_en && wr_data[16]) ? 1 : 0;
      pend_r = (m_restr != 0 || (rate_req && rate_to_restricted)) ? 1 : 0;
      ok = sel;
      if (sel && v == 0 && pend_r) begin m_err = 1; ok = 0; end
      prev_ack = m_ack; m_ack = 0; m_load = 0;
      if (m_busy) begin
        if (div_done) begin
          m_busy = 0;
          if (m_forcing) begin m_forcing = 0; m_ack = 1; m_restr = rate_to_restricted; end
        end
        if (ok) begin if (q.size() > 0) m_ovf = 1; else q.push_back(v); end
      end else if (q.size() > 0) begin
        m_code = q.pop_front(); m_busy = 1; m_load = 1;
        if (ok) q.push_back(v);
      end else if (ok) begin
        m_code = v; m_busy = 1; m_load = 1;
      end else if (rate_req && !m_forcing && !prev_ack) begin
        if (rate_to_restricted && m_code == 0) begin
          m_code = 1; m_busy = 1; m_load = 1; m_forcing = 1;
        end else begin
          m_ack = 1; m_restr = rate_to_restricted;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // divider stand-in
  always @(negedge clk) begin
    cyc++;
    div_done = 0;
    if (rst_n) begin
      if (dcnt > 0) begin dcnt--; if (dcnt == 0) div_done = 1; end
      if (div_load) dcnt = LAT;
      chk("R1 code", int'(rd_data[1:0]), m_code);
      chk("R3 busy", int'(rd_data[8]), m_busy);
      chk("R8 err", int'(rd_data[9]), m_err);
      chk("R5 ovf", int'(rd_data[10]), m_ovf);
      chk("R6 restricted", int'(rd_data[11]), m_restr);
      chk("R7 ack", int'(rate_ack), m_ack);
      chk("R4 load", int'(div_load), m_load);
      chk("R1 div_code", int'(div_code), m_code);
    end
  end

  task automatic wr(input int val, input bit en);
    @(negedge clk);
    wr_en = 1; wr_data = 32'(val) | (en ? 32'h1_0000 : 32'h0);
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic req(input bit restr);
    @(negedge clk);
    rate_req = 1; rate_to_restricted = restr;
    do @(negedge clk); while (!rate_ack);
    rate_req = 0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset word", int'(rd_data), 0);
    wr(3, 0); settle();
    chk("R1 no-enable write ignored", int'(rd_data), 0);
    wr(2, 1);
    chk("R3 load after write", int'(rd_data[8]), 1);
    settle();
    chk("R3 code applied", int'(rd_data[1:0]), 2);
    // R4/R5 queue and overflow
    wr(1, 1); wr(3, 1); wr(0, 1); settle();
    chk("R4 held write applied", int'(rd_data[1:0]), 3);
    chk("R5 overflow set", int'(rd_data[10]), 1);
    // R7 no rewrite needed
    req(1); settle();
    chk("R7 nonzero code kept", int'(rd_data[1:0]), 3);
    chk("R7 restricted set", int'(rd_data[11]), 1);
    // R8 reject code 0
    wr(0, 1); settle();
    chk("R8 zero refused", int'(rd_data[1:0]), 3);
    chk("R8 error set", int'(rd_data[9]), 1);
    req(0); wr(0, 1); settle();
    chk("R7 restricted cleared, zero allowed", int'(rd_data[1:0]), 0);
    // R6 forced rewrite
    req(1); settle();
    chk("R6 forced to 1", int'(rd_data[1:0]), 1);
    chk("R6 restricted", int'(rd_data[11]), 1);
    // R9 request waits on busy and held write
    req(0); wr(2, 1);
    @(negedge clk); wr_en = 1; wr_data = 32'h1_0000;
    @(negedge clk); wr_en = 0; wr_data = '0;
    req(1); settle();
    chk("R9 held zero fixed by rewrite", int'(rd_data[1:0]), 1);
    chk("R9 restricted after wait", int'(rd_data[11]), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule